// File: doc/BRIEF.md
# Interrupt Cause and Moderation Unit

This block gathers interrupt causes from a network controller into a sticky pending register and exposes a single level interrupt line. The line asserts only when a pending cause is also enabled in the mask register. A throttle counter then holds off further assertions for a programmable number of timebase ticks. Causes can be posted with an "immediate" qualifier that bypasses the throttle. Writes that enable mask bits, and expiries of the block's own delay timers, also bypass it.

Four delay timers run on a shared timebase strobe, `tick_i`. The chip's timebase pulses it for one clock once every 1024 ns, so every timer and throttle count is worth 1024 ns. Two timers serve the receive side and two serve the transmit side. In each pair, the relative timer restarts on every kick. The absolute timer starts on the first kick and runs out regardless of later kicks. Any expiry posts the side's cause bit as immediate. Software reads the pending register through a read strobe, which returns the value, clears it and drops the line.

Top module: `irq_moderator`

## Requirements
- R1: After reset the line is low, the pending register and the mask are zero, and the throttle counter is expired.
- R2: A bit pulsed on `cause_i` appears in `pend_o` after the next clock edge and stays set until a pending read.
- R3: A pending cause asserts `irq_o` two clock edges after its post when its mask bit is set and the throttle has expired. A cause whose mask bit is clear never asserts the line.
- R4: When the line rises, the throttle counter loads `thr_ival_i`. It counts down by one per `tick_i` and must reach zero before a non-immediate cause can assert the line. An interval of 0 means no throttling.
- R5: A cause posted with `cause_now_i` high asserts the line two edges later even while the throttle counter is nonzero.
- R6: A mask-set write asserts the line two edges later for causes that are already pending and now unmasked, even while the throttle counter is nonzero.
- R7: Once no pending cause is unmasked (for example after a mask-clear write), the line drops on the next edge. The pending bits stay set.
- R8: While `pend_rd_i` is high, `pend_o` shows the pending value. The edge that ends the read clears the register and drops the line, but a cause posted in the same cycle as the read stays pending.
- R9: A receive kick loads the relative receive timer from `rx_rel_i`, and every later kick restarts it. After that many ticks with no further kick, cause bit RX_CAUSE (bit 7 by default) is posted as immediate.
- R10: The absolute receive timer loads `rx_abs_i` on a kick only while it is idle. Later kicks do not restart it, so it posts bit RX_CAUSE that many ticks after the first kick.
- R11: The transmit relative and absolute timers behave like the receive pair. They load from `tx_rel_i` and `tx_abs_i` on `tx_kick_i` and post cause bit TX_CAUSE (bit 0 by default) as immediate.
- R12: A timer whose load value is 0 ignores kicks and never posts a cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cause_i | input | NUM_CAUSES | One-cycle cause pulses, one bit per cause |
| cause_now_i | input | 1 | Marks the causes posted this cycle as immediate |
| mask_set_i | input | 1 | Sets the mask bits given in `mask_wdata_i` |
| mask_clr_i | input | 1 | Clears the mask bits given in `mask_wdata_i` |
| mask_wdata_i | input | NUM_CAUSES | Bit selection for mask writes |
| pend_rd_i | input | 1 | Read-to-clear strobe for the pending register |
| pend_o | output | NUM_CAUSES | Pending register value |
| tick_i | input | 1 | One-cycle timebase strobe, one per 1024 ns |
| thr_ival_i | input | TMR_W | Throttle interval in ticks |
| rx_kick_i | input | 1 | Receive event that starts the receive timers |
| tx_kick_i | input | 1 | Transmit event that starts the transmit timers |
| rx_rel_i | input | TMR_W | Relative receive timer load value |
| rx_abs_i | input | TMR_W | Absolute receive timer load value |
| tx_rel_i | input | TMR_W | Relative transmit timer load value |
| tx_abs_i | input | TMR_W | Absolute transmit timer load value |
| irq_o | output | 1 | Interrupt line |

## Verification
The bench builds the block with NUM_CAUSES=8 and TMR_W=8, keeping the receive cause on bit 7 and the transmit cause on bit 0. It drives `tick_i` itself, so throttle intervals and timer loads of only a few ticks cover the full expiry path, including the tick on which a counter reaches zero. This brings the bypasses within a few dozen cycles: immediate posts, mask-set writes and timer expiries can all be tested against a throttle counter that is still running. Restart and no-restart behaviour is shown by kicking a timer again partway through its count.

// File: rtl/irq_mod_pkg.sv
package irq_mod_pkg;

    // Timer flavour: relative restarts on every kick, absolute only when idle
    typedef enum logic {
        TMR_RELATIVE = 1'b0,
        TMR_ABSOLUTE = 1'b1
    } tmr_kind_e;

    localparam int DEF_CAUSES = 8;
    localparam int DEF_TMR_W  = 16;
    localparam int NUM_TMRS   = 4;

    // Next state of the interrupt line
    function automatic logic line_next(
        input logic cur,
        input logic active,
        input logic rd,
        input logic thr_zero,
        input logic imm
    );
        logic nxt;
        if (rd || !active) nxt = 1'b0;
        else if (cur)      nxt = 1'b1;
        else               nxt = thr_zero || imm;
        return nxt;
    endfunction

endpackage

// File: rtl/irq_dly_timer.sv
module irq_dly_timer
    import irq_mod_pkg::*;
#(
    parameter int        TMR_W = DEF_TMR_W,
    parameter tmr_kind_e KIND  = TMR_RELATIVE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             kick_i,
    input  logic [TMR_W-1:0] load_i,
    input  logic             tick_i,
    output logic             fire_o
);

    localparam logic [TMR_W-1:0] ONE = TMR_W'(1);

    logic [TMR_W-1:0] cnt_q;
    logic             run_q;
    logic             restart;

    generate
        if (KIND == TMR_ABSOLUTE) begin : g_abs
            assign restart = kick_i && (load_i != '0) && !run_q;
        end else begin : g_rel
            assign restart = kick_i && (load_i != '0);
        end
    endgenerate

    assign fire_o = run_q && tick_i && (cnt_q == ONE) && !restart;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (restart) begin
            cnt_q <= load_i;
            run_q <= 1'b1;
        end else if (run_q && tick_i) begin
            cnt_q <= cnt_q - ONE;
            if (cnt_q == ONE) run_q <= 1'b0;
        end
    end

endmodule

// File: rtl/irq_throttle.sv
module irq_throttle
    import irq_mod_pkg::*;
#(
    parameter int TMR_W = DEF_TMR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reload_i,
    input  logic [TMR_W-1:0] ival_i,
    input  logic             tick_i,
    output logic             zero_o,
    output logic [TMR_W-1:0] cnt_o
);

    logic [TMR_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                          cnt_q <= '0;
        else if (reload_i)                cnt_q <= ival_i;
        else if (tick_i && cnt_q != '0)   cnt_q <= cnt_q - TMR_W'(1);
    end

    assign zero_o = (cnt_q == '0);
    assign cnt_o  = cnt_q;

endmodule

// File: rtl/irq_moderator.sv
module irq_moderator
    import irq_mod_pkg::*;
#(
    parameter int NUM_CAUSES = DEF_CAUSES,
    parameter int TMR_W      = DEF_TMR_W,
    parameter int RX_CAUSE   = 7,
    parameter int TX_CAUSE   = 0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_CAUSES-1:0] cause_i,
    input  logic                  cause_now_i,
    input  logic                  mask_set_i,
    input  logic                  mask_clr_i,
    input  logic [NUM_CAUSES-1:0] mask_wdata_i,
    input  logic                  pend_rd_i,
    output logic [NUM_CAUSES-1:0] pend_o,
    input  logic                  tick_i,
    input  logic [TMR_W-1:0]      thr_ival_i,
    input  logic                  rx_kick_i,
    input  logic                  tx_kick_i,
    input  logic [TMR_W-1:0]      rx_rel_i,
    input  logic [TMR_W-1:0]      rx_abs_i,
    input  logic [TMR_W-1:0]      tx_rel_i,
    input  logic [TMR_W-1:0]      tx_abs_i,
    output logic                  irq_o
);

    localparam int N = NUM_CAUSES;

    logic [N-1:0] pend_q, mask_q, tmr_cause;
    logic         irq_q, irq_d, imm_q, imm_set, active, rise, thr_zero;
    logic [TMR_W-1:0] thr_cnt;

    // Timer slots: 0 rx relative, 1 rx absolute, 2 tx relative, 3 tx absolute
    logic             tmr_kick [NUM_TMRS];
    logic [TMR_W-1:0] tmr_load [NUM_TMRS];
    logic [NUM_TMRS-1:0] tmr_fire;

    assign tmr_kick[0] = rx_kick_i;  assign tmr_load[0] = rx_rel_i;
    assign tmr_kick[1] = rx_kick_i;  assign tmr_load[1] = rx_abs_i;
    assign tmr_kick[2] = tx_kick_i;  assign tmr_load[2] = tx_rel_i;
    assign tmr_kick[3] = tx_kick_i;  assign tmr_load[3] = tx_abs_i;

    generate
        for (genvar g = 0; g < NUM_TMRS; g++) begin : g_tmr
            localparam tmr_kind_e K = (g % 2 == 1) ? TMR_ABSOLUTE : TMR_RELATIVE;
            irq_dly_timer #(.TMR_W(TMR_W), .KIND(K)) u_tmr (
                .clk    (clk),
                .rst    (rst),
                .kick_i (tmr_kick[g]),
                .load_i (tmr_load[g]),
                .tick_i (tick_i),
                .fire_o (tmr_fire[g])
            );
        end
    endgenerate

    always_comb begin
        tmr_cause = '0;
        tmr_cause[RX_CAUSE] = tmr_fire[0] | tmr_fire[1];
        tmr_cause[TX_CAUSE] = tmr_cause[TX_CAUSE] | tmr_fire[2] | tmr_fire[3];
    end

    irq_throttle #(.TMR_W(TMR_W)) u_thr (
        .clk      (clk),
        .rst      (rst),
        .reload_i (rise),
        .ival_i   (thr_ival_i),
        .tick_i   (tick_i),
        .zero_o   (thr_zero),
        .cnt_o    (thr_cnt)
    );

    assign active  = |(pend_q & mask_q);
    assign imm_set = (cause_now_i && (cause_i != '0)) || (tmr_fire != '0) || mask_set_i;
    assign irq_d   = line_next(irq_q, active, pend_rd_i, thr_zero, imm_q);
    assign rise    = irq_d && !irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            mask_q <= '0;
            irq_q  <= 1'b0;
            imm_q  <= 1'b0;
        end else begin
            pend_q <= (pend_rd_i ? '0 : pend_q) | cause_i | tmr_cause;
            mask_q <= (mask_q | (mask_set_i ? mask_wdata_i : '0))
                      & ~(mask_clr_i ? mask_wdata_i : '0);
            irq_q  <= irq_d;
            imm_q  <= imm_set || (imm_q && !(rise || pend_rd_i || !active));
        end
    end

    assign pend_o = pend_q;
    assign irq_o  = irq_q;

endmodule

// File: rtl/irq_moderator_chk.sv
module irq_moderator_chk #(
    parameter int NUM_CAUSES = 8,
    parameter int TMR_W      = 16
) (
    input logic                  clk,
    input logic                  rst,
    input logic [NUM_CAUSES-1:0] cause_i,
    input logic                  pend_rd_i,
    input logic [NUM_CAUSES-1:0] pend_o,
    input logic                  irq_o,
    input logic [NUM_CAUSES-1:0] mask_q,
    input logic                  imm_q,
    input logic [TMR_W-1:0]      thr_cnt,
    input logic [TMR_W-1:0]      thr_ival_i
);

    // R2
    cause_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (cause_i != '0) |=> ((pend_o & $past(cause_i)) == $past(cause_i)));

    // R8
    read_drops_chk: assert property (@(posedge clk) disable iff (rst)
        pend_rd_i |=> !irq_o);

    // R7
    no_active_low_chk: assert property (@(posedge clk) disable iff (rst)
        ((pend_o & mask_q) == '0) |=> !irq_o);

    // R4
    rise_gated_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> ($past(thr_cnt) == '0 || $past(imm_q)));

    // R4
    thr_reload_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> (thr_cnt == $past(thr_ival_i)));

endmodule

bind irq_moderator irq_moderator_chk #(
    .NUM_CAUSES (NUM_CAUSES),
    .TMR_W      (TMR_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cause_i    (cause_i),
    .pend_rd_i  (pend_rd_i),
    .pend_o     (pend_o),
    .irq_o      (irq_o),
    .mask_q     (mask_q),
    .imm_q      (imm_q),
    .thr_cnt    (thr_cnt),
    .thr_ival_i (thr_ival_i)
);

// File: tb/irq_moderator_test.sv
module irq_moderator_test;

    localparam int CLK_PERIOD = 10;
    localparam int NC = 8;
    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NC-1:0] cause = '0;
    logic          cause_now = 1'b0;
    logic          mset = 1'b0, mclr = 1'b0;
    logic [NC-1:0] mdata = '0;
    logic          rd = 1'b0;
    logic [NC-1:0] pend;
    logic          tick = 1'b0;
    logic [TW-1:0] thr_ival = '0;
    logic          rx_kick = 1'b0, tx_kick = 1'b0;
    logic [TW-1:0] rx_rel = '0, rx_abs = '0, tx_rel = '0, tx_abs = '0;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    irq_moderator #(.NUM_CAUSES(NC), .TMR_W(TW), .RX_CAUSE(7), .TX_CAUSE(0)) uut (
        .clk(clk), .rst(rst), .cause_i(cause), .cause_now_i(cause_now),
        .mask_set_i(mset), .mask_clr_i(mclr), .mask_wdata_i(mdata),
        .pend_rd_i(rd), .pend_o(pend), .tick_i(tick), .thr_ival_i(thr_ival),
        .rx_kick_i(rx_kick), .tx_kick_i(tx_kick),
        .rx_rel_i(rx_rel), .rx_abs_i(rx_abs), .tx_rel_i(tx_rel), .tx_abs_i(tx_abs),
        .irq_o(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic post(input logic [NC-1:0] bits, input logic now);
        cause = bits; cause_now = now; cyc(1); cause = '0; cause_now = 1'b0;
    endtask

    task automatic mask_wr(input logic set, input logic [NC-1:0] bits);
        mset = set; mclr = !set; mdata = bits; cyc(1);
        mset = 1'b0; mclr = 1'b0; mdata = '0;
    endtask

    task automatic do_read(input string req, input int exp);
        rd = 1'b1;
        chk(req, pend, exp);
        cyc(1); rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1; cyc(1); tick = 1'b0; cyc(1);
        end
    endtask

    task automatic kick(input logic rx, input logic tx);
        rx_kick = rx; tx_kick = tx; cyc(1); rx_kick = 1'b0; tx_kick = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 irq", irq, 0);
        chk("R1 pend", pend, 0);
    endtask

    task automatic t_mask_gate;
        post(8'h04, 1'b0);
        chk("R2 pend set", pend, 8'h04);
        cyc(3);
        chk("R3 masked stays low", irq, 0);
        mask_wr(1'b1, 8'h04); cyc(1);
        chk("R6 mask set asserts", irq, 1);
        do_read("R8 read value", 8'h04);
        chk("R8 cleared", pend, 0);
        chk("R8 line drops", irq, 0);
    endtask

    task automatic t_throttle;
        thr_ival = 8'd5;
        post(8'h04, 1'b0); cyc(1);
        chk("R3 unmasked asserts", irq, 1);
        do_read("R8 read", 8'h04);
        post(8'h04, 1'b0); cyc(2);
        chk("R4 held by throttle", irq, 0);
        ticks(4);
        chk("R4 still held after 4 ticks", irq, 0);
        ticks(1);
        chk("R4 asserts at expiry", irq, 1);
        do_read("R8 read", 8'h04);
    endtask

    task automatic t_immediate;
        mask_wr(1'b1, 8'h08); cyc(1);
        chk("R6 nothing pending", irq, 0);
        post(8'h08, 1'b1); cyc(1);
        chk("R5 immediate bypasses throttle", irq, 1);
        do_read("R8 read", 8'h08);
    endtask

    task automatic t_mask_drop;
        post(8'h08, 1'b1); cyc(1);
        chk("R5 asserted", irq, 1);
        mask_wr(1'b0, 8'h08); cyc(1);
        chk("R7 mask clear drops line", irq, 0);
        chk("R7 pending kept", pend, 8'h08);
        mask_wr(1'b1, 8'h08); cyc(1);
        chk("R6 re-enable asserts under throttle", irq, 1);
        do_read("R8 read", 8'h08);
    endtask

    task automatic t_read_race;
        rd = 1'b1; cause = 8'h20; cyc(1); rd = 1'b0; cause = '0;
        chk("R8 post during read survives", pend, 8'h20);
        do_read("R8 read", 8'h20);
    endtask

    task automatic t_rx_rel;
        mask_wr(1'b1, 8'h81); cyc(1);
        rx_rel = 8'd3; rx_abs = 8'd0;
        kick(1'b1, 1'b0);
        ticks(2);
        chk("R9 not yet expired", pend, 0);
        ticks(1);
        chk("R9 rx cause posted", pend, 8'h80);
        chk("R9 line up under throttle", irq, 1);
        do_read("R9 read", 8'h80);
        kick(1'b1, 1'b0); ticks(2);
        kick(1'b1, 1'b0); ticks(2);
        chk("R9 restart delays expiry", pend, 0);
        ticks(1);
        chk("R9 expiry after restart", pend, 8'h80);
        do_read("R9 read", 8'h80);
    endtask

    task automatic t_rx_abs;
        rx_rel = 8'd0; rx_abs = 8'd4;
        kick(1'b1, 1'b0); ticks(2);
        kick(1'b1, 1'b0); ticks(1);
        chk("R10 not yet expired", pend, 0);
        ticks(1);
        chk("R10 absolute not restarted", pend, 8'h80);
        chk("R10 line up", irq, 1);
        do_read("R10 read", 8'h80);
    endtask

    task automatic t_disabled;
        rx_rel = 8'd0; rx_abs = 8'd0; tx_rel = 8'd0; tx_abs = 8'd0;
        kick(1'b1, 1'b1); ticks(6);
        chk("R12 zero load no cause", pend, 0);
        chk("R12 zero load no line", irq, 0);
    endtask

    task automatic t_tx;
        tx_rel = 8'd2; tx_abs = 8'd0;
        kick(1'b0, 1'b1); ticks(1);
        chk("R11 tx not yet", pend, 0);
        ticks(1);
        chk("R11 tx relative posts bit 0", pend, 8'h01);
        chk("R11 line up", irq, 1);
        do_read("R11 read", 8'h01);
        tx_rel = 8'd0; tx_abs = 8'd3;
        kick(1'b0, 1'b1); ticks(1);
        kick(1'b0, 1'b1); ticks(2);
        chk("R11 tx absolute posts bit 0", pend, 8'h01);
        do_read("R11 read", 8'h01);
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        t_reset();
        t_mask_gate();
        t_throttle();
        t_immediate();
        t_mask_drop();
        t_read_race();
        t_rx_rel();
        t_rx_abs();
        t_disabled();
        t_tx();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule